// File: doc/BRIEF.md
# Register-Programmed Serial Word Master

This block is a serial-peripheral-interface master that software drives through a small register bus. It moves one word per command, from 8 to 32 bits long, over single-bit data lines. A command register holds the word length, clock mode, bit order, lane enables and chip-select control. A start bit launches the word. Words queue up for sending in a small transmit FIFO, and received words collect in a small receive FIFO.

Progress and faults are kept in two status registers. A ready flag marks each finished word. Sticky error flags record overflow and underrun on either FIFO, and writing 1 to a flag clears it. Software can also flush either FIFO through a request bit that clears itself. The serial clock comes from the system clock through a divider that is fixed at elaboration.

Bus reads are combinational: `bus_rdata` follows `bus_addr`. A read or write takes effect at the clock edge where `bus_rd` or `bus_wr` is high.

Top module: `spi_word_master`

## Requirements
- R1: After reset, every `cs_n` line is high and `sck` is low. The command register (offset 0x000) reads 0, the transfer status (0x010) reads 0, and the FIFO status (0x014) reads 0x00000005, meaning both FIFOs are empty.
- R2: Command bits 4:0 hold the word length minus one. With bit 16 clear, a word goes out on `mosi` most significant bit first. The word received on `miso` is placed in the receive FIFO in the same bit order.
- R3: Command bits 29:28 set the clock mode. Bit 29 is the idle level of `sck`. Bit 28 selects sampling on the trailing edge (1) or on the leading edge (0). Data changes on the other edge.
- R4: With command bit 16 set, bit 0 of the word is sent and received first.
- R5: Command bits 27:26 select one of four chip selects; no more than one `cs_n` line is ever low. With bit 21 set, the selected line takes the value of bit 20. With bit 21 clear, the selected line is low only while a word is shifting.
- R6: Writing 1 to command bit 31 while idle starts a word, and the bit reads back as 1 until the shifter starts. Bit 31 then clears by itself. A start written while a word is shifting is ignored.
- R7: Transfer-status bit 30 sets when a word completes. Writing 1 to it clears it.
- R8: Writing 1 to FIFO-status bit 15 flushes the receive FIFO, and writing 1 to bit 14 flushes the transmit FIFO. The request bit reads 1 for one cycle and then returns to 0, leaving that FIFO empty.
- R9: A write to the transmit port (offset 0x108) while the transmit FIFO is full drops the data and sets FIFO-status bit 7. Bit 3 reports transmit-full, and bit 8 is the OR of bits 7:4.
- R10: A read of the receive port (offset 0x188) while the receive FIFO is empty returns 0 and sets bit 4. A completed word that finds the receive FIFO full is dropped and sets bit 5.
- R11: Starting a word with transmit enabled (command bit 11) and an empty transmit FIFO sets bit 6 and sends all zeros.
- R12: FIFO-status bits 7:4 are write-one-to-clear. Writing back a value just read clears every flag that was set and leaves the level bits 3:0 as they were.
- R13: With command bit 11 clear, `mosi` stays 0 and the transmit FIFO is not popped. With command bit 12 clear, the received word is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; pops the receive port |
| bus_addr | input | 9 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| sck | output | 1 | Serial clock |
| cs_n | output | 4 | Active-low chip selects |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench builds the block with a FIFO depth of 2 and a half-period divider of 2. With depth 2, the transmit-overflow and receive-overflow cases are reached after only three words. With the divider at 2, even a 32-bit word finishes in about 130 cycles, so all four clock modes, both bit orders, and lengths of 8, 12, 16 and 32 bits fit in one short run. A behavioural slave on the bench side drives `miso` and captures `mosi` on the edges its own mode decoding predicts.

// File: rtl/spi_wm_pkg.sv
package spi_wm_pkg;
  localparam logic [8:0] ADR_CMD = 9'h000;
  localparam logic [8:0] ADR_XST = 9'h010;
  localparam logic [8:0] ADR_FST = 9'h014;
  localparam logic [8:0] ADR_TXP = 9'h108;
  localparam logic [8:0] ADR_RXP = 9'h188;

  localparam int B_GO     = 31;
  localparam int B_RDY    = 30;
  localparam int B_CPOL   = 29;
  localparam int B_CPHA   = 28;
  localparam int B_CSSW   = 21;
  localparam int B_CSVAL  = 20;
  localparam int B_LSBBIT = 16;
  localparam int B_RXEN   = 12;
  localparam int B_TXEN   = 11;
  localparam int B_RXFL   = 15;
  localparam int B_TXFL   = 14;

  // position inside the word of the idx-th bit on the wire
  function automatic logic [4:0] wire_slot(input logic [4:0] idx,
                                           input logic [4:0] len_m1,
                                           input logic lsb_first);
    return lsb_first ? idx : (len_m1 - idx);
  endfunction

  // edge number e (0 = first leading edge) samples when its parity equals cpha
  function automatic logic is_sample_edge(input logic e_lsb, input logic cpha);
    return e_lsb == cpha;
  endfunction
endpackage

// File: rtl/spi_wm_fifo.sv
module spi_wm_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign rdata = empty ? '0 : mem[rp];

  wire do_push = push && !full;
  wire do_pop  = pop && !empty;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= wdata;
  end
endmodule

// File: rtl/spi_wm_shifter.sv
module spi_wm_shifter
  import spi_wm_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [4:0]  len_m1,
  input  logic        cpol,
  input  logic        cpha,
  input  logic        lsb_first,
  input  logic [31:0] tx_word,
  input  logic        miso,
  output logic        busy,
  output logic        done,
  output logic [31:0] rx_word,
  output logic        sck,
  output logic        mosi
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DW-1:0] div_cnt;
  logic [5:0]    edge_idx;
  logic          phase, cpol_l, cpha_l, lsb_l, mosi_q;
  logic [4:0]    len_l;
  logic [31:0]   txw, rxw;

  wire       tick      = busy && (div_cnt == DW'(HALF_DIV - 1));
  wire       last_edge = (edge_idx == {len_l, 1'b1});
  wire [4:0] cur_bit   = edge_idx[5:1];
  wire [4:0] nxt_bit   = cur_bit + 5'd1;

  assign sck     = busy ? (cpol_l ^ phase) : cpol;
  assign mosi    = mosi_q;
  assign rx_word = rxw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      div_cnt  <= '0;
      edge_idx <= '0;
      phase    <= 1'b0;
      cpol_l   <= 1'b0;
      cpha_l   <= 1'b0;
      lsb_l    <= 1'b0;
      len_l    <= '0;
      txw      <= '0;
      rxw      <= '0;
      mosi_q   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        busy     <= 1'b1;
        div_cnt  <= '0;
        edge_idx <= '0;
        phase    <= 1'b0;
        cpol_l   <= cpol;
        cpha_l   <= cpha;
        lsb_l    <= lsb_first;
        len_l    <= len_m1;
        txw      <= tx_word;
        rxw      <= '0;
        mosi_q   <= cpha ? 1'b0 : tx_word[wire_slot(5'd0, len_m1, lsb_first)];
      end else if (busy) begin
        if (!tick) begin
          div_cnt <= div_cnt + DW'(1);
        end else begin
          div_cnt  <= '0;
          phase    <= ~phase;
          edge_idx <= edge_idx + 6'd1;
          if (is_sample_edge(edge_idx[0], cpha_l))
            rxw[wire_slot(cur_bit, len_l, lsb_l)] <= miso;
          else if (cpha_l)
            mosi_q <= txw[wire_slot(cur_bit, len_l, lsb_l)];
          else if (!last_edge)
            mosi_q <= txw[wire_slot(nxt_bit, len_l, lsb_l)];
          if (last_edge) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
  import spi_wm_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int HALF_DIV   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [8:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sck,
  output logic [3:0]  cs_n,
  output logic        mosi,
  input  logic        miso
);
  logic [30:0] cmd_q;
  logic        go_q, ready_q, rxfl_q, txfl_q;
  logic [3:0]  err_q;   // {tx_ovf, tx_unr, rx_ovf, rx_unr}

  logic [31:0] tx_head, rx_head, rx_word, tx_word;
  logic        tx_full, tx_empty, rx_full, rx_empty;
  logic        eng_busy, eng_done;

  wire wr_cmd = bus_wr && (bus_addr == ADR_CMD);
  wire wr_xst = bus_wr && (bus_addr == ADR_XST);
  wire wr_fst = bus_wr && (bus_addr == ADR_FST);
  wire wr_txp = bus_wr && (bus_addr == ADR_TXP);
  wire rd_rxp = bus_rd && (bus_addr == ADR_RXP);

  wire tx_en = cmd_q[B_TXEN];
  wire rx_en = cmd_q[B_RXEN];

  // named internal events
  wire start_word   = go_q && !eng_busy;
  wire tx_pop       = start_word && tx_en && !tx_empty;
  wire tx_starved   = start_word && tx_en && tx_empty;
  wire tx_push_drop = wr_txp && tx_full;
  wire rx_push      = eng_done && rx_en;
  wire rx_push_drop = rx_push && rx_full;
  wire rx_pop_empty = rd_rxp && rx_empty;

  assign tx_word = tx_pop ? tx_head : 32'h0;

  spi_wm_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_txf (
    .clk(clk), .rst_n(rst_n), .flush(txfl_q),
    .push(wr_txp), .wdata(bus_wdata), .pop(tx_pop),
    .rdata(tx_head), .full(tx_full), .empty(tx_empty));

  spi_wm_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_rxf (
    .clk(clk), .rst_n(rst_n), .flush(rxfl_q),
    .push(rx_push), .wdata(rx_word), .pop(rd_rxp),
    .rdata(rx_head), .full(rx_full), .empty(rx_empty));

  spi_wm_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start_word),
    .len_m1(cmd_q[4:0]), .cpol(cmd_q[B_CPOL]), .cpha(cmd_q[B_CPHA]),
    .lsb_first(cmd_q[B_LSBBIT]), .tx_word(tx_word), .miso(miso),
    .busy(eng_busy), .done(eng_done), .rx_word(rx_word),
    .sck(sck), .mosi(mosi));

  wire [3:0] err_set = {tx_push_drop, tx_starved, rx_push_drop, rx_pop_empty};
  wire [3:0] err_clr = wr_fst ? bus_wdata[7:4] : 4'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      go_q    <= 1'b0;
      ready_q <= 1'b0;
      rxfl_q  <= 1'b0;
      txfl_q  <= 1'b0;
      err_q   <= '0;
    end else begin
      if (wr_cmd) cmd_q <= bus_wdata[30:0];
      if (start_word)
        go_q <= 1'b0;
      else if (wr_cmd && bus_wdata[B_GO] && !eng_busy)
        go_q <= 1'b1;
      if (eng_done)
        ready_q <= 1'b1;
      else if (wr_xst && bus_wdata[B_RDY])
        ready_q <= 1'b0;
      rxfl_q <= wr_fst && bus_wdata[B_RXFL];
      txfl_q <= wr_fst && bus_wdata[B_TXFL];
      err_q  <= (err_q & ~err_clr) | err_set;
    end
  end

  // chip select
  logic [3:0] sel_oh;
  logic       cs_act;
  always_comb begin
    sel_oh = 4'b0001 << cmd_q[27:26];
    cs_act = cmd_q[B_CSSW] ? !cmd_q[B_CSVAL] : eng_busy;
    cs_n   = cs_act ? ~sel_oh : 4'hF;
  end

  always_comb begin
    case (bus_addr)
      ADR_CMD: bus_rdata = {go_q, cmd_q};
      ADR_XST: bus_rdata = {1'b0, ready_q, 30'h0};
      ADR_FST: bus_rdata = {16'h0, rxfl_q, txfl_q, 5'h0, |err_q, err_q,
                            tx_full, tx_empty, rx_full, rx_empty};
      ADR_RXP: bus_rdata = rx_head;
      default: bus_rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/spi_wm_checker.sv
module spi_wm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sck,
  input logic [3:0] cs_n,
  input logic       cpol,
  input logic       eng_busy,
  input logic       eng_done,
  input logic       go_q,
  input logic       ready_q,
  input logic       txfl_q,
  input logic       rxfl_q,
  input logic       tx_empty,
  input logic       rx_empty,
  input logic       tx_push_drop,
  input logic       tx_ovf
);
  AST_CS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);                                      // R5
  AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eng_busy) |-> sck == cpol);                             // R3
  AST_GO_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |=> eng_busy);                                           // R6
  AST_GO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |=> !go_q);                                              // R6
  AST_READY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> ready_q);                                        // R7
  AST_TX_FLUSHED: assert property (@(posedge clk) disable iff (!rst_n)
    txfl_q |=> tx_empty);                                         // R8
  AST_RX_FLUSHED: assert property (@(posedge clk) disable iff (!rst_n)
    rxfl_q |=> rx_empty);                                         // R8
  AST_TX_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push_drop |=> tx_ovf);                                     // R9
endmodule

bind spi_word_master spi_wm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
  .cpol(cmd_q[29]), .eng_busy(eng_busy), .eng_done(eng_done),
  .go_q(go_q), .ready_q(ready_q), .txfl_q(txfl_q), .rxfl_q(rxfl_q),
  .tx_empty(tx_empty), .rx_empty(rx_empty),
  .tx_push_drop(tx_push_drop), .tx_ovf(err_q[3]));

// File: tb/test_spi_word_master.sv
module test_spi_word_master;
  localparam int CLK_P = 10;
  localparam logic [8:0] A_CMD = 9'h000, A_XST = 9'h010, A_FST = 9'h014,
                         A_TXP = 9'h108, A_RXP = 9'h188;

  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0, miso;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        sck, mosi;
  logic [3:0]  cs_n;

  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  spi_word_master #(.FIFO_DEPTH(2), .HALF_DIV(2)) i_spi_word_master (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  // behavioural slave
  logic        s_cpol = 0, s_cpha = 0, s_lsb = 0;
  int          s_len = 7, s_k = 0, c_k = 0;
  logic [31:0] s_word = '0, c_word = '0;

  function automatic int slot(input int k);
    return s_lsb ? k : (s_len - k);
  endfunction

  always @* miso = (s_k >= 0 && s_k <= s_len) ? s_word[slot(s_k)] : 1'b0;

  always @(sck) begin
    if ((sck !== s_cpol) != s_cpha) begin
      if (c_k <= s_len) c_word[slot(c_k)] = mosi;
      c_k = c_k + 1;
    end else begin
      s_k = s_k + 1;
    end
  end

  task automatic arm(input logic [1:0] mode, input int len, input logic lsb,
                     input logic [31:0] w);
    s_cpol = mode[1]; s_cpha = mode[0]; s_lsb = lsb; s_len = len;
    s_word = w; c_word = '0; c_k = 0;
    s_k = mode[0] ? -1 : 0;
  endtask

  function automatic logic [31:0] mk(input logic [1:0] mode, input logic [1:0] sel,
      input logic sw, input logic val, input logic rxe, input logic txe,
      input logic lsb, input logic [4:0] len);
    logic [31:0] c;
    c = 32'h4000_0000;
    c[29:28] = mode; c[27:26] = sel; c[21] = sw; c[20] = val;
    c[16] = lsb; c[12] = rxe; c[11] = txe; c[4:0] = len;
    return c;
  endfunction

  function automatic logic [31:0] msk(input int len);
    return (len >= 31) ? 32'hFFFF_FFFF : ((32'h1 << (len + 1)) - 32'h1);
  endfunction

  task automatic chk(input logic ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    bus_rd = 1; bus_addr = a;
    #(CLK_P/4);
    d = bus_rdata;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic wait_ready();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(A_XST, v);
      if (v[30]) return;
    end
    chk(1'b0, "R7 ready timeout", 32'h0, 32'h4000_0000);
  endtask

  task automatic xfer(input logic [1:0] mode, input int len, input logic lsb,
                      input logic txe, input logic rxe, input logic [31:0] sw,
                      output logic [31:0] cap);
    logic [31:0] c;
    c = mk(mode, 2'd0, 1'b1, 1'b0, rxe, txe, lsb, 5'(len));
    wr(A_CMD, c);
    arm(mode, len, lsb, sw);
    wr(A_CMD, c | 32'h8000_0000);
    wait_ready();
    cap = c_word;
    wr(A_XST, 32'h4000_0000);
  endtask

  task automatic word_pair(input logic [1:0] mode, input int len, input logic lsb,
                           input logic [31:0] tw, input logic [31:0] sw,
                           input string tag);
    logic [31:0] cap, r;
    wr(A_TXP, tw);
    xfer(mode, len, lsb, 1'b1, 1'b1, sw, cap);
    chk(cap == (tw & msk(len)), {tag, " mosi word"}, cap, tw & msk(len));
    rd(A_RXP, r);
    chk(r == (sw & msk(len)), {tag, " miso word"}, r, sw & msk(len));
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk(cs_n == 4'hF, "R1 cs_n", {28'h0, cs_n}, 32'hF);
    chk(sck == 1'b0, "R1 sck", {31'h0, sck}, 32'h0);
    rd(A_CMD, v); chk(v == 32'h0, "R1 cmd", v, 32'h0);
    rd(A_XST, v); chk(v == 32'h0, "R1 xst", v, 32'h0);
    rd(A_FST, v); chk(v == 32'h5, "R1 fst", v, 32'h5);
  endtask

  task automatic t_basic();
    logic [31:0] v;
    word_pair(2'd0, 7, 1'b0, 32'h0000_00A5, 32'h0000_003C, "R2 8b");
    word_pair(2'd0, 31, 1'b0, 32'h1234_5678, 32'hCAFE_F00D, "R2 32b");
    rd(A_XST, v); chk(v == 32'h0, "R7 ready cleared", v, 32'h0);
  endtask

  task automatic t_modes();
    wr(A_CMD, mk(2'd3, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd15));
    #1; chk(sck == 1'b1, "R3 idle high", {31'h0, sck}, 32'h1);
    word_pair(2'd3, 15, 1'b0, 32'h0000_B00F, 32'h0000_6E21, "R3 mode3");
    word_pair(2'd1, 11, 1'b0, 32'h0000_0A5C, 32'h0000_0963, "R3 mode1");
    word_pair(2'd2, 7, 1'b0, 32'h0000_0081, 32'h0000_00E6, "R3 mode2");
  endtask

  task automatic t_lsb();
    word_pair(2'd0, 7, 1'b1, 32'h0000_0013, 32'h0000_00C8, "R4 lsb0");
    word_pair(2'd1, 15, 1'b1, 32'h0000_A001, 32'h0000_1234, "R4 lsb1");
  endtask

  task automatic t_cs();
    logic [31:0] cap;
    wr(A_CMD, mk(2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd7));
    chk(cs_n == 4'b1011, "R5 sw low sel2", {28'h0, cs_n}, 32'hB);
    wr(A_CMD, mk(2'd0, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5'd7));
    chk(cs_n == 4'hF, "R5 sw high", {28'h0, cs_n}, 32'hF);
    wr(A_CMD, mk(2'd0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd7));
    chk(cs_n == 4'b0111, "R5 sw low sel3", {28'h0, cs_n}, 32'h7);
    wr(A_CMD, mk(2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd7));
    chk(cs_n == 4'hF, "R5 hw idle", {28'h0, cs_n}, 32'hF);
    arm(2'd0, 7, 1'b0, 32'h0);
    wr(A_CMD, mk(2'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 5'd7) | 32'h8000_0000);
    repeat (4) @(negedge clk);
    chk(cs_n == 4'b1101, "R5 hw active", {28'h0, cs_n}, 32'hD);
    wait_ready();
    chk(cs_n == 4'hF, "R5 hw released", {28'h0, cs_n}, 32'hF);
    wr(A_XST, 32'h4000_0000);
    cap = 0;
  endtask

  task automatic t_go();
    logic [31:0] c, v;
    wr(A_TXP, 32'h11); wr(A_TXP, 32'h22);
    c = mk(2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 5'd7);
    wr(A_CMD, c);
    arm(2'd0, 7, 1'b0, 32'h0);
    wr(A_CMD, c | 32'h8000_0000);
    rd(A_CMD, v); chk(v[31] == 1'b1, "R6 go pending", v, c | 32'h8000_0000);
    rd(A_CMD, v); chk(v[31] == 1'b0, "R6 go self-clear", v, c);
    wr(A_CMD, c | 32'h8000_0000);
    wait_ready();
    chk(c_word == 32'h11, "R6 first word", c_word, 32'h11);
    wr(A_XST, 32'h4000_0000);
    repeat (80) @(negedge clk);
    rd(A_XST, v); chk(v == 32'h0, "R6 busy go ignored", v, 32'h0);
    rd(A_FST, v); chk(v[2] == 1'b0, "R6 tx word kept", v, 32'h1);
  endtask

  task automatic t_flush();
    logic [31:0] v, cap;
    wr(A_FST, 32'h4000);
    rd(A_FST, v); chk(v[14] == 1'b1, "R8 tx flush pending", v, 32'h4000);
    rd(A_FST, v); chk(v[15:0] == 16'h0005, "R8 tx flush done", v, 32'h5);
    xfer(2'd0, 7, 1'b0, 1'b0, 1'b1, 32'h77, cap);
    wr(A_FST, 32'h8000);
    rd(A_FST, v); chk(v[15] == 1'b1, "R8 rx flush pending", v, 32'h8000);
    rd(A_FST, v); chk(v[15:0] == 16'h0005, "R8 rx flush done", v, 32'h5);
  endtask

  task automatic t_txovf();
    logic [31:0] v, cap;
    wr(A_TXP, 32'h31); wr(A_TXP, 32'h42); wr(A_TXP, 32'h53);
    rd(A_FST, v);
    chk(v[8:7] == 2'b11 && v[3] == 1'b1, "R9 tx overflow", v, 32'h189);
    wr(A_FST, 32'h80);
    xfer(2'd0, 7, 1'b0, 1'b1, 1'b0, 32'h0, cap);
    chk(cap == 32'h31, "R9 word0", cap, 32'h31);
    xfer(2'd0, 7, 1'b0, 1'b1, 1'b0, 32'h0, cap);
    chk(cap == 32'h42, "R9 word1", cap, 32'h42);
    rd(A_FST, v); chk(v[15:0] == 16'h0005, "R9 third dropped", v, 32'h5);
  endtask

  task automatic t_rxerr();
    logic [31:0] v, cap;
    rd(A_RXP, v); chk(v == 32'h0, "R10 empty read data", v, 32'h0);
    rd(A_FST, v); chk(v[8] && v[4], "R10 rx underrun", v, 32'h115);
    wr(A_FST, 32'h10);
    xfer(2'd0, 7, 1'b0, 1'b0, 1'b1, 32'h5A, cap);
    xfer(2'd0, 7, 1'b0, 1'b0, 1'b1, 32'h6B, cap);
    xfer(2'd0, 7, 1'b0, 1'b0, 1'b1, 32'h7C, cap);
    rd(A_FST, v); chk(v[5] && v[1], "R10 rx overflow", v, 32'h126);
    rd(A_RXP, v); chk(v == 32'h5A, "R10 rx word0", v, 32'h5A);
    rd(A_RXP, v); chk(v == 32'h6B, "R10 rx word1", v, 32'h6B);
    wr(A_FST, 32'hF0);
  endtask

  task automatic t_txunr();
    logic [31:0] v, cap;
    xfer(2'd0, 7, 1'b0, 1'b1, 1'b0, 32'h0, cap);
    chk(cap == 32'h0, "R11 zeros sent", cap, 32'h0);
    rd(A_FST, v); chk(v[6] && v[8], "R11 tx underrun", v, 32'h145);
  endtask

  task automatic t_w1c();
    logic [31:0] v, r;
    rd(A_RXP, r);
    rd(A_FST, v);
    chk(v[4] && v[6], "R12 flags set", v, 32'h155);
    wr(A_FST, v);
    rd(A_FST, r); chk(r == 32'h5, "R12 write-back clears", r, 32'h5);
  endtask

  task automatic t_enables();
    logic [31:0] v, cap;
    wr(A_TXP, 32'hF0);
    xfer(2'd0, 7, 1'b0, 1'b0, 1'b0, 32'h99, cap);
    chk(cap == 32'h0, "R13 mosi quiet", cap, 32'h0);
    rd(A_FST, v);
    chk(v[2] == 1'b0 && v[0] == 1'b1, "R13 fifos untouched", v, 32'h1);
    wr(A_FST, 32'h4000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_modes();
    t_lsb();
    t_cs();
    t_go();
    t_flush();
    t_txovf();
    t_rxerr();
    t_txunr();
    t_w1c();
    t_enables();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule